// File: doc/BRIEF.md
# Cache Invalidate-All Sequencer

This block runs a whole-cache discard for a core with split instruction and data caches. A one-cycle start command causes it to step through every set index. On each clock it writes both tag arrays at the same index, and it clears the valid and modified state of every way in that set. Dirty data is thrown away and never copied out, so the external bus stays quiet for the whole sweep.

When the final set has been cleared, the sequencer announces the flush on the external bus with a special cycle. The address strobe pulses low for one clock. The byte enables carry the invalidate code, and the cycle-type lines carry the special-cycle encoding. The cycle is held until the system returns ready. On that edge the operation ends and the bus returns to its idle values, so that refill reads can follow at once.

Top module: `cache_inval_seq`

## Requirements
- R1: During reset, and whenever busy is low, the outputs sit at their idle values: busy=0, done=0, adsN=1, beN=8'hFF, mio=0, dc=0, wr=0, and both tag write enables are 0. Reset is asynchronous and active low, and it can abort an operation in progress.
- R2: A startCmd sampled high while idle raises busy on the next cycle. From that cycle on, for NUM_SETS consecutive cycles, both tag ports write set 0, then 1, and so on up to NUM_SETS-1, one set per cycle. Each write has all way-mask bits set and drives write data valid=0 and modified=0.
- R3: No bus activity takes place while a tag port is writing: adsN=1, beN=8'hFF and wr=0 throughout the sweep. Modified lines are therefore dropped with no writeback.
- R4: The special cycle starts in the cycle directly after the write to set NUM_SETS-1. In that cycle adsN=0, beN=8'hFD (only bit 1 low), mio=0, dc=0 and wr=1. adsN is low for exactly one cycle.
- R5: After the address-strobe cycle, beN=8'hFD and wr=1 hold, with busy high, until rdyN is sampled low. A low rdyN during the address-strobe cycle itself is ignored.
- R6: When rdyN is sampled low at a clock edge after the address-strobe cycle, the next cycle shows done=1, busy=0 and idle bus values. done lasts one cycle. A low rdyN while idle has no effect.
- R7: A startCmd that arrives while busy is ignored. The set sequence does not restart, no extra special cycle is issued, and the block stays idle after done.
- R8: A tag write enable is high only while busy is high. One operation makes exactly NUM_SETS writes on each tag port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startCmd | input | 1 | One-cycle request to invalidate both caches |
| busy | output | 1 | High from start until ready is taken |
| done | output | 1 | One-cycle completion pulse |
| icTagWe | output | 1 | Instruction tag array write enable |
| icTagSet | output | SET_W | Instruction tag array set index |
| icTagWayMask | output | NUM_WAYS | Instruction tag array way select |
| icTagValid | output | 1 | Instruction tag write data, valid bit |
| dcTagWe | output | 1 | Data tag array write enable |
| dcTagSet | output | SET_W | Data tag array set index |
| dcTagWayMask | output | NUM_WAYS | Data tag array way select |
| dcTagValid | output | 1 | Data tag write data, valid bit |
| dcTagModified | output | 1 | Data tag write data, modified bit |
| adsN | output | 1 | Bus address strobe, active low |
| beN | output | 8 | Bus byte enables, active low |
| mio | output | 1 | Cycle type: memory (1) or I/O (0) |
| dc | output | 1 | Cycle type: data (1) or code (0) |
| wr | output | 1 | Cycle type: write (1) or read (0) |
| rdyN | input | 1 | Bus ready from the system, active low |

## Verification
The hardest case to reach from the ports is an input that lands in the one cycle where it must be ignored. Examples are a ready that arrives while the address strobe is still low, or a second start that comes during the sweep or during the wait for ready. A vector table gives, for each run, the wait before ready, an optional early ready pulse timed to the strobe cycle, and the cycle at which a duplicate start is injected. Every cycle of each run is then compared with the expected set index and bus values. Directed tests then cover reset in the middle of a sweep and ready while idle.

// File: rtl/cinv_pkg.sv
package cinv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INVAL = 2'd1,
    ST_ADS   = 2'd2,
    ST_WAIT  = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic inval;
    logic ads;
    logic spec;
  } seqStrobe_t;

  localparam logic [7:0] BE_IDLE    = 8'hFF;
  localparam logic [7:0] BE_INV_ALL = 8'hFD;
  localparam logic       SPEC_MIO   = 1'b0;
  localparam logic       SPEC_DC    = 1'b0;
  localparam logic       SPEC_WR    = 1'b1;

endpackage

// File: rtl/cinv_ctrl.sv
module cinv_ctrl
  import cinv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startCmd,
  input  logic       rdyN,
  input  logic       lastIdx,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_WAIT) && !rdyN;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startCmd) stateNext = ST_INVAL;
      ST_INVAL: if (lastIdx)  stateNext = ST_ADS;
      ST_ADS:   stateNext = ST_WAIT;
      ST_WAIT:  if (!rdyN)    stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.clrIdx = (state == ST_IDLE) && startCmd;
    strobe.incIdx = (state == ST_INVAL);
    strobe.inval  = (state == ST_INVAL);
    strobe.ads    = (state == ST_ADS);
    strobe.spec   = (state == ST_ADS) || (state == ST_WAIT);
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/cinv_dp.sv
module cinv_dp
  import cinv_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 4,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  output logic                lastIdx,
  output logic                icTagWe,
  output logic [SET_W-1:0]    icTagSet,
  output logic [NUM_WAYS-1:0] icTagWayMask,
  output logic                icTagValid,
  output logic                dcTagWe,
  output logic [SET_W-1:0]    dcTagSet,
  output logic [NUM_WAYS-1:0] dcTagWayMask,
  output logic                dcTagValid,
  output logic                dcTagModified,
  output logic                adsN,
  output logic [7:0]          beN,
  output logic                mio,
  output logic                dc,
  output logic                wr
);

  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  logic [SET_W-1:0] setIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              setIdx <= '0;
    else if (strobe.clrIdx) setIdx <= '0;
    else if (strobe.incIdx) setIdx <= setIdx + 1'b1;
  end

  assign lastIdx = (setIdx == LAST_SET);

  // both tag ports sweep the same set together
  assign icTagWe       = strobe.inval;
  assign icTagSet      = setIdx;
  assign icTagValid    = 1'b0;
  assign dcTagWe       = strobe.inval;
  assign dcTagSet      = setIdx;
  assign dcTagValid    = 1'b0;
  assign dcTagModified = 1'b0;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign icTagWayMask[w] = strobe.inval;
    assign dcTagWayMask[w] = strobe.inval;
  end

  // bus side: idle values unless the special cycle is running
  assign adsN = !strobe.ads;
  assign beN  = strobe.spec ? BE_INV_ALL : BE_IDLE;
  assign mio  = strobe.spec ? SPEC_MIO : 1'b0;
  assign dc   = strobe.spec ? SPEC_DC  : 1'b0;
  assign wr   = strobe.spec ? SPEC_WR  : 1'b0;

endmodule

// File: rtl/cache_inval_seq.sv
module cache_inval_seq
  import cinv_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int NUM_WAYS = 4,
  localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startCmd,
  output logic                busy,
  output logic                done,
  output logic                icTagWe,
  output logic [SET_W-1:0]    icTagSet,
  output logic [NUM_WAYS-1:0] icTagWayMask,
  output logic                icTagValid,
  output logic                dcTagWe,
  output logic [SET_W-1:0]    dcTagSet,
  output logic [NUM_WAYS-1:0] dcTagWayMask,
  output logic                dcTagValid,
  output logic                dcTagModified,
  output logic                adsN,
  output logic [7:0]          beN,
  output logic                mio,
  output logic                dc,
  output logic                wr,
  input  logic                rdyN
);

  seqStrobe_t strobe;
  logic       lastIdx;

  cinv_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startCmd (startCmd),
    .rdyN     (rdyN),
    .lastIdx  (lastIdx),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done)
  );

  cinv_dp #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .lastIdx       (lastIdx),
    .icTagWe       (icTagWe),
    .icTagSet      (icTagSet),
    .icTagWayMask  (icTagWayMask),
    .icTagValid    (icTagValid),
    .dcTagWe       (dcTagWe),
    .dcTagSet      (dcTagSet),
    .dcTagWayMask  (dcTagWayMask),
    .dcTagValid    (dcTagValid),
    .dcTagModified (dcTagModified),
    .adsN          (adsN),
    .beN           (beN),
    .mio           (mio),
    .dc            (dc),
    .wr            (wr)
  );

endmodule

// File: rtl/cinv_seq_chk.sv
module cinv_seq_chk #(
  parameter int SET_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             icTagWe,
  input logic [SET_W-1:0] icTagSet,
  input logic             dcTagWe,
  input logic             adsN,
  input logic [7:0]       beN,
  input logic             mio,
  input logic             dc,
  input logic             wr,
  input logic             rdyN
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (adsN && beN == 8'hFF && !wr && !mio && !dc && !icTagWe && !dcTagWe));

  p_first_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (icTagWe && icTagSet == '0));

  p_set_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (icTagWe && $past(icTagWe)) |-> (icTagSet == SET_W'($past(icTagSet) + 1'b1)));

  p_no_bus_inval_r3: assert property (@(posedge clk) disable iff (!rstN)
    (icTagWe || dcTagWe) |-> (adsN && beN == 8'hFF && !wr));

  p_ads_code_r4: assert property (@(posedge clk) disable iff (!rstN)
    !adsN |-> (beN == 8'hFD && !mio && !dc && wr));

  p_ads_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    !adsN |=> adsN);

  p_spec_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !adsN |=> (beN == 8'hFD && wr && busy));

  p_done_after_rdy_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (!busy && $past(!rdyN) && $past(beN == 8'hFD)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_write_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (icTagWe || dcTagWe) |-> busy);

endmodule

bind cache_inval_seq cinv_seq_chk #(.SET_W(SET_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .done     (done),
  .icTagWe  (icTagWe),
  .icTagSet (icTagSet),
  .dcTagWe  (dcTagWe),
  .adsN     (adsN),
  .beN      (beN),
  .mio      (mio),
  .dc       (dc),
  .wr       (wr),
  .rdyN     (rdyN)
);

// File: tb/cache_inval_seq_tb.sv
module cache_inval_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSETS      = 8;
  localparam int NWAYS      = 2;
  localparam int SW         = $clog2(NSETS);
  localparam int NVEC       = 6;

  // per run: ready wait, early ready in strobe cycle, cycle of duplicate start (-1 none)
  localparam int VEC_WAIT [NVEC] = '{0, 4, 0, 2, 1, 6};
  localparam int VEC_EARLY[NVEC] = '{0, 0, 1, 1, 0, 1};
  localparam int VEC_DUP  [NVEC] = '{-1, -1, -1, 3, 9, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startCmd = 1'b0;
  logic rdyN = 1'b1;
  logic busy, done, icTagWe, dcTagWe, icTagValid, dcTagValid, dcTagModified;
  logic [SW-1:0] icTagSet, dcTagSet;
  logic [NWAYS-1:0] icTagWayMask, dcTagWayMask;
  logic adsN, mio, dc, wr;
  logic [7:0] beN;

  int nChecks = 0;
  int nErrors = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_inval_seq #(.NUM_SETS(NSETS), .NUM_WAYS(NWAYS)) u_dut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .busy(busy), .done(done),
    .icTagWe(icTagWe), .icTagSet(icTagSet), .icTagWayMask(icTagWayMask),
    .icTagValid(icTagValid), .dcTagWe(dcTagWe), .dcTagSet(dcTagSet),
    .dcTagWayMask(dcTagWayMask), .dcTagValid(dcTagValid),
    .dcTagModified(dcTagModified), .adsN(adsN), .beN(beN), .mio(mio),
    .dc(dc), .wr(wr), .rdyN(rdyN)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // idle bus and tag ports
  task automatic chkIdle(input string req);
    chk({req, " adsN"}, int'(adsN), 1);
    chk({req, " beN"}, int'(beN), 8'hFF);
    chk({req, " mio/dc/wr"}, int'({mio, dc, wr}), 0);
    chk({req, " tag we"}, int'({icTagWe, dcTagWe}), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  task automatic runOp(input int waitRdy, input int early, input int dupAt);
    int rdyCyc;
    rdyCyc = NSETS + 1 + waitRdy;
    @(negedge clk);
    startCmd = 1'b1;
    for (int cyc = 0; cyc <= rdyCyc; cyc++) begin
      @(negedge clk);
      startCmd = (cyc == dupAt);
      chk("R2 busy", int'(busy), 1);
      chk("R6 done low while busy", int'(done), 0);
      if (cyc < NSETS) begin
        chk("R2 ic we", int'(icTagWe), 1);
        chk("R2 dc we", int'(dcTagWe), 1);
        chk("R2 ic set", int'(icTagSet), cyc);
        chk("R2 dc set", int'(dcTagSet), cyc);
        chk("R2 way masks", int'({icTagWayMask, dcTagWayMask}), (1 << (2*NWAYS)) - 1);
        chk("R2 clear data", int'({icTagValid, dcTagValid, dcTagModified}), 0);
        chk("R3 ads idle", int'(adsN), 1);
        chk("R3 be idle", int'(beN), 8'hFF);
        chk("R3 wr idle", int'(wr), 0);
      end else if (cyc == NSETS) begin
        chk("R4 ads low", int'(adsN), 0);
        chk("R4 be code", int'(beN), 8'hFD);
        chk("R4 type", int'({mio, dc, wr}), 3'b001);
        chk("R8 no write", int'(icTagWe | dcTagWe), 0);
      end else begin
        chk("R4 ads single", int'(adsN), 1);
        chk("R5 be held", int'(beN), 8'hFD);
        chk("R5 wr held", int'(wr), 1);
        chk("R8 no write", int'(icTagWe | dcTagWe), 0);
      end
      rdyN = !((cyc == NSETS && early != 0) || cyc == rdyCyc);
    end
    @(negedge clk);
    startCmd = 1'b0;
    rdyN = 1'b1;
    chk("R6 done pulse", int'(done), 1);
    chk("R6 busy low", int'(busy), 0);
    chkIdle("R6 bus released");
    @(negedge clk);
    chk("R6 done single", int'(done), 0);
    chk("R7 no restart", int'(busy), 0);
    chkIdle("R7 stays idle");
  endtask

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chkIdle("R1 reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after reset");

    for (int v = 0; v < NVEC; v++)
      runOp(VEC_WAIT[v], VEC_EARLY[v], VEC_DUP[v]);

    // R6: ready while idle does nothing
    rdyN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6 idle rdy done", int'(done), 0);
    chk("R6 idle rdy busy", int'(busy), 0);
    rdyN = 1'b1;

    // R1: reset in the middle of a sweep
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 mid sweep busy", int'(busy), 1);
    rstN = 1'b0;
    #1;
    chk("R1 abort busy", int'(busy), 0);
    chkIdle("R1 abort");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1 after abort");

    // R8: full run after abort still makes exactly NSETS writes
    runOp(0, 0, -1);

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule